// File: doc/BRIEF.md
# Processor status flag unit

This block keeps the 16-bit status word of a 16-bit processor core. Six condition flags follow the results of the arithmetic unit, and three control flags shape how the core behaves. Each cycle the unit may take an ALU result together with its operands, the carry or borrow out of the top bit, an operation class and a byte/word width. From these it works out carry, parity, half-carry, zero, sign and overflow. The control flags are changed by explicit set and clear commands, by interrupt entry and return, and by loading a whole word popped from the stack. The packed word is always present on an output, so the core can push it.

A small two-state controller follows interrupt service. The state `ST_RUN` is normal execution. An interrupt entry moves it to `ST_SERVICE` and saves the trap and interrupt-enable bits before clearing both. A return in `ST_SERVICE` puts the saved bits back and moves to `ST_RUN`. A return seen in `ST_RUN` has nothing to restore and is ignored. A second entry in `ST_SERVICE` saves again and stays in that state. Every update is registered, so its effect shows on the outputs one clock after the input cycle.

Top module: `psw_unit`

## Requirements
- R1: After reset the word reads 16'hF002: every flag is 0, including interrupt-enable, and the controller is in `ST_RUN`.
- R2: Bit layout of the word: carry 0, parity 2, half-carry 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10, overflow 11. Bits 15:12 and bit 1 always read 1. Bits 3 and 5 always read 0.
- R3: For op_class 0 (add) and 1 (subtract), carry takes the value of `carry_msb`, which is the carry or borrow out of the top bit at the selected width.
- R4: For add and subtract, half-carry is set when there is a carry out of bit 3 or a borrow from bit 4 into bit 3. This equals a[4]^b[4]^result[4].
- R5: Zero is set when the result is zero and sign copies the top bit of the result. With `byte_mode` high, only result bits 7:0 count for both.
- R6: Parity is set when result bits 7:0 hold an even number of ones, in both byte and word mode.
- R7: Overflow is set on a signed overflow at the selected width. For add this is equal operand signs and a different result sign. For subtract this is different operand signs and a result sign different from operand a.
- R8: For op_class 2 (logic), carry and overflow are cleared, half-carry keeps its value, and zero, sign and parity update. `carry_msb` is ignored.
- R9: `ctl_cmd` encoding: 1 sets interrupt-enable, 2 clears it, 3 sets direction, 4 clears it. Codes 0 and 5 to 7 have no effect. No code touches trap.
- R10: `irq_enter` clears trap and interrupt-enable and saves them. `irq_return` in `ST_SERVICE` restores them. `irq_return` in `ST_RUN` changes nothing.
- R11: Trap changes only through a pop, an interrupt entry or an interrupt return. A pop loads all nine flags from their bit positions in `pop_word` and leaves the fixed bits at their fixed values.
- R12: Priority: a pop overrides every other input in the same cycle. An interrupt event overrides a command on interrupt-enable. With `alu_valid` low, or op_class 3, the condition flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_valid | input | 1 | ALU result present this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 no flag update |
| byte_mode | input | 1 | 1 = byte-width operation |
| alu_a | input | 16 | First operand |
| alu_b | input | 16 | Second operand |
| alu_result | input | 16 | ALU result |
| carry_msb | input | 1 | Carry/borrow out of the top bit at the selected width |
| ctl_cmd | input | 3 | Control flag command |
| irq_enter | input | 1 | Interrupt recognised |
| irq_return | input | 1 | Return from interrupt service |
| pop_valid | input | 1 | Load the whole word from pop_word |
| pop_word | input | 16 | Word popped from the stack |
| psw | output | 16 | Packed status word |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Half-carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| tf | output | 1 | Trap flag |
| ief | output | 1 | Interrupt-enable flag |
| df | output | 1 | Direction flag |

## Verification
The bench uses byte operations whose upper result byte is not zero. A unit that ignored the width would report a wrong zero, sign or overflow for these. It also uses a word result whose low byte has even parity while the full word has odd parity, which catches parity taken over all 16 bits. One logic operation follows a subtract that set half-carry, with `carry_msb` held high; a unit that cleared half-carry or passed the carry through would fail there. The interrupt tests return once in `ST_SERVICE` and once in `ST_RUN`, and they collide a pop and an entry with commands in the same cycle. These catch a unit that loses or invents the saved trap bit, or that applies the wrong priority.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W = 16;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IE = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2,
        OPC_NONE  = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_SET_IE  = 3'd1,
        CMD_CLR_IE  = 3'd2,
        CMD_SET_DIR = 3'd3,
        CMD_CLR_DIR = 3'd4
    } ctl_cmd_e;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } cond_t;

    function automatic cond_t cond_from_word(input logic [PSW_W-1:0] w);
        cond_t c;
        c.cf = w[POS_CF];
        c.pf = w[POS_PF];
        c.af = w[POS_AF];
        c.zf = w[POS_ZF];
        c.sf = w[POS_SF];
        c.of = w[POS_OF];
        return c;
    endfunction

    function automatic logic [PSW_W-1:0] pack_word(input cond_t c, input logic t,
                                                   input logic ie, input logic d);
        logic [PSW_W-1:0] w;
        w = 16'hF002;
        w[POS_CF] = c.cf;
        w[POS_PF] = c.pf;
        w[POS_AF] = c.af;
        w[POS_ZF] = c.zf;
        w[POS_SF] = c.sf;
        w[POS_OF] = c.of;
        w[POS_TF] = t;
        w[POS_IE] = ie;
        w[POS_DF] = d;
        return w;
    endfunction

endpackage

// File: rtl/psw_cond_calc.sv
module psw_cond_calc
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_msb,
    input  cond_t             cur,
    output cond_t             nxt
);
    localparam int BYTE_W = 8;
    localparam int NIB    = 4;

    logic a_s, b_s, r_s, is_zero, even_par, half;

    always_comb begin
        a_s      = byte_mode ? op_a[BYTE_W-1]   : op_a[DATA_W-1];
        b_s      = byte_mode ? op_b[BYTE_W-1]   : op_b[DATA_W-1];
        r_s      = byte_mode ? result[BYTE_W-1] : result[DATA_W-1];
        is_zero  = byte_mode ? (result[BYTE_W-1:0] == '0) : (result == '0);
        even_par = ~^result[BYTE_W-1:0];
        half     = op_a[NIB] ^ op_b[NIB] ^ result[NIB];
    end

    always_comb begin
        nxt = cur;
        unique case (op_class_e'(op_class))
            OPC_ADD: begin
                nxt = '{cf: carry_msb, pf: even_par, af: half, zf: is_zero, sf: r_s,
                        of: (a_s == b_s) && (r_s != a_s)};
            end
            OPC_SUB: begin
                nxt = '{cf: carry_msb, pf: even_par, af: half, zf: is_zero, sf: r_s,
                        of: (a_s != b_s) && (r_s != a_s)};
            end
            OPC_LOGIC: begin
                nxt = '{cf: 1'b0, pf: even_par, af: cur.af, zf: is_zero, sf: r_s, of: 1'b0};
            end
            OPC_NONE: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/psw_ctrl_fsm.sv
module psw_ctrl_fsm
    import psw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] ctl_cmd,
    input  logic       irq_enter,
    input  logic       irq_return,
    input  logic       pop_valid,
    input  logic       pop_tf,
    input  logic       pop_ie,
    input  logic       pop_df,
    output logic       tf,
    output logic       ie,
    output logic       df
);
    svc_state_e state_q, state_d;
    logic tf_q, ie_q, df_q, sv_tf_q, sv_ie_q;
    logic tf_d, ie_d, df_d, sv_tf_d, sv_ie_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tf_q    <= 1'b0;
            ie_q    <= 1'b0;
            df_q    <= 1'b0;
            sv_tf_q <= 1'b0;
            sv_ie_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tf_q    <= tf_d;
            ie_q    <= ie_d;
            df_q    <= df_d;
            sv_tf_q <= sv_tf_d;
            sv_ie_q <= sv_ie_d;
        end
    end

    always_comb begin
        state_d = state_q;
        tf_d    = tf_q;
        ie_d    = ie_q;
        df_d    = df_q;
        sv_tf_d = sv_tf_q;
        sv_ie_d = sv_ie_q;

        case (ctl_cmd_e'(ctl_cmd))
            CMD_SET_IE:  ie_d = 1'b1;
            CMD_CLR_IE:  ie_d = 1'b0;
            CMD_SET_DIR: df_d = 1'b1;
            CMD_CLR_DIR: df_d = 1'b0;
            default:     ;
        endcase

        unique case (state_q)
            ST_RUN: begin
                if (irq_enter) begin
                    sv_tf_d = tf_q;
                    sv_ie_d = ie_q;
                    tf_d    = 1'b0;
                    ie_d    = 1'b0;
                    state_d = ST_SERVICE;
                end
            end
            ST_SERVICE: begin
                if (irq_enter) begin
                    sv_tf_d = tf_q;
                    sv_ie_d = ie_q;
                    tf_d    = 1'b0;
                    ie_d    = 1'b0;
                end else if (irq_return) begin
                    tf_d    = sv_tf_q;
                    ie_d    = sv_ie_q;
                    state_d = ST_RUN;
                end
            end
        endcase

        if (pop_valid) begin
            state_d = state_q;
            sv_tf_d = sv_tf_q;
            sv_ie_d = sv_ie_q;
            tf_d    = pop_tf;
            ie_d    = pop_ie;
            df_d    = pop_df;
        end
    end

    assign tf = tf_q;
    assign ie = ie_q;
    assign df = df_q;

endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [1:0]        op_class,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              carry_msb,
    input  logic [2:0]        ctl_cmd,
    input  logic              irq_enter,
    input  logic              irq_return,
    input  logic              pop_valid,
    input  logic [15:0]       pop_word,
    output logic [15:0]       psw,
    output logic              cf,
    output logic              pf,
    output logic              af,
    output logic              zf,
    output logic              sf,
    output logic              of,
    output logic              tf,
    output logic              ief,
    output logic              df
);
    cond_t cond_q, cond_calc;

    psw_cond_calc #(.DATA_W(DATA_W)) i_calc (
        .byte_mode (byte_mode),
        .op_class  (op_class),
        .op_a      (alu_a),
        .op_b      (alu_b),
        .result    (alu_result),
        .carry_msb (carry_msb),
        .cur       (cond_q),
        .nxt       (cond_calc)
    );

    psw_ctrl_fsm i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_cmd    (ctl_cmd),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .pop_valid  (pop_valid),
        .pop_tf     (pop_word[POS_TF]),
        .pop_ie     (pop_word[POS_IE]),
        .pop_df     (pop_word[POS_DF]),
        .tf         (tf),
        .ie         (ief),
        .df         (df)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
        end else if (pop_valid) begin
            cond_q <= cond_from_word(pop_word);
        end else if (alu_valid) begin
            cond_q <= cond_calc;
        end
    end

    always_comb begin
        psw = pack_word(cond_q, tf, ief, df);
        cf  = cond_q.cf;
        pf  = cond_q.pf;
        af  = cond_q.af;
        zf  = cond_q.zf;
        sf  = cond_q.sf;
        of  = cond_q.of;
    end

endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        alu_valid,
    input logic [1:0]  op_class,
    input logic        byte_mode,
    input logic [15:0] alu_result,
    input logic [2:0]  ctl_cmd,
    input logic        irq_enter,
    input logic        irq_return,
    input logic        pop_valid,
    input logic        cf,
    input logic        pf,
    input logic        af,
    input logic        zf,
    input logic        of,
    input logic        tf,
    input logic        ief,
    input logic        df
);
    assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && op_class == 2'd2 && !pop_valid) |=> (!cf && !of));

    assert_logic_keeps_af_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && op_class == 2'd2 && !pop_valid) |=> $stable(af));

    assert_word_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && op_class != 2'd3 && !byte_mode && alu_result == 16'h0 && !pop_valid) |=> zf);

    assert_low_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && op_class != 2'd3 && !pop_valid) |=> (pf == ~^$past(alu_result[7:0])));

    assert_entry_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && !pop_valid) |=> (!tf && !ief));

    assert_trap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_valid && !irq_enter && !irq_return) |=> $stable(tf));

    assert_set_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cmd == 3'd3 && !pop_valid) |=> df);

    assert_idle_cond_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_valid && !pop_valid) |=> ($stable(cf) && $stable(zf) && $stable(of)));

endmodule

bind psw_unit psw_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_valid  (alu_valid),
    .op_class   (op_class),
    .byte_mode  (byte_mode),
    .alu_result (alu_result),
    .ctl_cmd    (ctl_cmd),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .pop_valid  (pop_valid),
    .cf         (cf),
    .pf         (pf),
    .af         (af),
    .zf         (zf),
    .of         (of),
    .tf         (tf),
    .ief        (ief),
    .df         (df)
);

// File: tb/test_psw_unit.sv
module test_psw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_valid = 1'b0;
    logic [1:0]  op_class = 2'd3;
    logic        byte_mode = 1'b0;
    logic [15:0] alu_a = '0, alu_b = '0, alu_result = '0;
    logic        carry_msb = 1'b0;
    logic [2:0]  ctl_cmd = 3'd0;
    logic        irq_enter = 1'b0, irq_return = 1'b0;
    logic        pop_valid = 1'b0;
    logic [15:0] pop_word = '0;
    logic [15:0] psw;
    logic        cf, pf, af, zf, sf, of, tf, ief, df;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    psw_unit i_psw_unit (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .op_class(op_class),
        .byte_mode(byte_mode), .alu_a(alu_a), .alu_b(alu_b), .alu_result(alu_result),
        .carry_msb(carry_msb), .ctl_cmd(ctl_cmd), .irq_enter(irq_enter),
        .irq_return(irq_return), .pop_valid(pop_valid), .pop_word(pop_word),
        .psw(psw), .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of),
        .tf(tf), .ief(ief), .df(df)
    );

    // expected word from the R2 layout
    function automatic logic [15:0] mk(input logic c, p, a, z, s, o, t, i, d);
        return {4'hF, o, d, i, t, s, z, 1'b0, a, 1'b0, p, 1'b1, c};
    endfunction

    task automatic chk(input string req, input logic [15:0] exp);
        logic [15:0] flags;
        n_chk++;
        if (psw !== exp) begin
            n_fail++;
            $display("FAIL %s psw actual=%h expected=%h", req, psw, exp);
        end
        flags = {4'hF, of, df, ief, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf};
        n_chk++;
        if (flags !== exp) begin
            n_fail++;
            $display("FAIL %s flag pins actual=%h expected=%h", req, flags, exp);
        end
    endtask

    task automatic idle();
        alu_valid = 1'b0; op_class = 2'd3; ctl_cmd = 3'd0;
        irq_enter = 1'b0; irq_return = 1'b0; pop_valid = 1'b0;
    endtask

    task automatic alu(input logic [1:0] cls, input logic bm, input logic [15:0] a, b, r,
                       input logic c);
        alu_valid = 1'b1; op_class = cls; byte_mode = bm;
        alu_a = a; alu_b = b; alu_result = r; carry_msb = c;
        @(negedge clk);
        idle();
    endtask

    task automatic cmd(input logic [2:0] code);
        ctl_cmd = code;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        chk("R1 reset word", 16'hF002);
    endtask

    task automatic t_arith();
        alu(2'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1);
        chk("R3 R5 R6 word add carry to zero", mk(1,1,1,1,0,0, 0,0,0));
        alu(2'd0, 1'b1, 16'h127F, 16'h0001, 16'h1380, 1'b0);
        chk("R7 R5 byte add overflow", mk(0,0,1,0,1,1, 0,0,0));
        alu(2'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 1'b1);
        chk("R3 R4 word sub borrow", mk(1,1,1,0,1,0, 0,0,0));
        alu(2'd1, 1'b0, 16'h0010, 16'h0010, 16'h0000, 1'b0);
        chk("R4 sub no half borrow", mk(0,1,0,1,0,0, 0,0,0));
        alu(2'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b0);
        chk("R7 word sub overflow", mk(0,1,1,0,0,1, 0,0,0));
        alu(2'd0, 1'b0, 16'h0100, 16'h0003, 16'h0103, 1'b0);
        chk("R6 parity low byte only", mk(0,1,0,0,0,0, 0,0,0));
    endtask

    task automatic t_logic();
        alu(2'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b0);
        alu(2'd2, 1'b0, 16'hFFFF, 16'h0100, 16'h0100, 1'b1);
        chk("R8 word logic keeps AF", mk(0,1,1,0,0,0, 0,0,0));
        alu(2'd2, 1'b1, 16'h5AFF, 16'h5A00, 16'h5A00, 1'b1);
        chk("R8 R5 byte logic zero", mk(0,1,1,1,0,0, 0,0,0));
    endtask

    task automatic t_hold();
        alu_valid = 1'b0; op_class = 2'd0; alu_result = 16'h0081; carry_msb = 1'b1;
        @(negedge clk);
        idle();
        chk("R12 valid low holds", mk(0,1,1,1,0,0, 0,0,0));
        alu(2'd3, 1'b0, 16'h0000, 16'h0000, 16'h8001, 1'b1);
        chk("R12 class 3 holds", mk(0,1,1,1,0,0, 0,0,0));
    endtask

    task automatic t_cmds();
        cmd(3'd1);
        chk("R9 set IF", mk(0,1,1,1,0,0, 0,1,0));
        cmd(3'd3);
        chk("R9 set DF", mk(0,1,1,1,0,0, 0,1,1));
        cmd(3'd5);
        chk("R9 code 5 ignored", mk(0,1,1,1,0,0, 0,1,1));
        cmd(3'd4);
        chk("R9 clear DF", mk(0,1,1,1,0,0, 0,1,0));
        cmd(3'd2);
        chk("R9 clear IF", mk(0,1,1,1,0,0, 0,0,0));
    endtask

    task automatic t_pop_irq();
        pop_valid = 1'b1; pop_word = 16'h0FD5;
        @(negedge clk);
        idle();
        chk("R11 pop loads nine flags", 16'hFFD7);
        irq_enter = 1'b1;
        @(negedge clk);
        idle();
        chk("R10 entry clears TF IF", mk(1,1,1,1,1,1, 0,0,1));
        cmd(3'd1);
        chk("R9 set IF in service", mk(1,1,1,1,1,1, 0,1,1));
        irq_return = 1'b1;
        @(negedge clk);
        idle();
        chk("R10 return restores", 16'hFFD7);
        cmd(3'd2);
        irq_return = 1'b1;
        @(negedge clk);
        idle();
        chk("R10 return in run ignored", mk(1,1,1,1,1,1, 1,0,1));
    endtask

    task automatic t_priority();
        pop_valid = 1'b1; pop_word = 16'h0000; ctl_cmd = 3'd1; irq_enter = 1'b1;
        alu_valid = 1'b1; op_class = 2'd0; alu_result = 16'h0000; carry_msb = 1'b1;
        @(negedge clk);
        idle();
        chk("R12 pop wins over all", 16'hF002);
        irq_return = 1'b1;
        @(negedge clk);
        idle();
        chk("R11 R10 pop kept run state", 16'hF002);
        ctl_cmd = 3'd1; irq_enter = 1'b1;
        @(negedge clk);
        idle();
        chk("R12 entry beats set IF", 16'hF002);
        irq_return = 1'b1;
        @(negedge clk);
        idle();
        chk("R10 restore saved zero", 16'hF002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_hold();
        t_cmds();
        t_pop_irq();
        t_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule